// File: doc/BRIEF.md
# Early Partial-Address Load Disambiguator

This block is the ordering side of a load/store queue in a clustered core. The effective address of a memory operation reaches the queue in two pieces. First, a narrow low-latency link delivers an 18-bit low-order slice. Later, the normal link delivers the complete address. As soon as a slice arrives, the block drives a cache-index strobe carrying the L1 set index and the TLB set index, so the array reads and the translation lookup can start. The block also compares each load's slice against every older store in the queue and grants loads that have no possible conflict.

A matching slice counts as a dependence even when the complete addresses later turn out to differ. This keeps the check conservative. When both complete addresses are known and they differ, the false dependence is cleared and the load may issue. When the complete addresses match, the load stays blocked until the conflicting store retires from the head of the queue. Entries are allocated at the tail in program order and retired from the head.

Top module: `lsq_early_disambig`

## Requirements
- R1: After reset the queue is empty (q_empty=1, q_full=0), and issue_valid and idx_strobe are 0.
- R2: Each accepted allocation takes the entry at alloc_idx, and alloc_idx then advances by one (modulo DEPTH). q_full rises once DEPTH entries are held. While the queue is full, a further allocation is ignored. After DEPTH retirements the queue reports empty again.
- R3: One cycle after early_valid, idx_strobe is 1 with idx_l1 = early_slice[11:4] and idx_tlb = early_slice[3:0]. The slice layout is: bits 17:12 partial tag, bits 11:4 L1 index, bits 3:0 TLB index.
- R4: A load is never granted before its own slice is known, or while any older store has no slice yet.
- R5: A load whose 18-bit slice equals that of an older store stays blocked while either complete address is unknown, even if the complete addresses differ.
- R6: Once both complete addresses are known and differ, that partial match no longer blocks the load.
- R7: A load whose complete address equals an older store's stays blocked while that store is in the queue.
- R8: A store younger than a load never blocks that load.
- R9: At most one load is granted per cycle, and the oldest eligible load goes first. A grant appears on issue_valid/issue_idx in the cycle after the load becomes eligible. Each load is granted once.
- R10: retire_valid removes the oldest entry, and this can release loads that were blocked by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_idx | output | 4 | Entry index the next allocation takes |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entries |
| early_valid | input | 1 | Early slice valid |
| early_idx | input | 4 | Entry the slice belongs to |
| early_slice | input | 18 | Partial tag, L1 index and TLB index |
| full_valid | input | 1 | Complete address valid |
| full_idx | input | 4 | Entry the address belongs to |
| full_addr | input | 32 | Complete effective address (low 18 bits form its slice) |
| retire_valid | input | 1 | Remove the oldest entry |
| issue_valid | output | 1 | A load is granted this cycle |
| issue_idx | output | 4 | Index of the granted load |
| idx_strobe | output | 1 | Start cache and TLB lookup |
| idx_l1 | output | 8 | L1 set index for the lookup |
| idx_tlb | output | 4 | TLB set index for the lookup |

## Verification
A corrupted slice or address bit in an entry shows up in one of two ways. Either a load is granted too early, which the bench sees on issue_valid/issue_idx in the very next cycle, or a load is never granted, which the bench sees when its expected grant is still pending a few cycles after the releasing event. Flipped age order or pointer state shows up as grants in the wrong order or at the wrong index, and as wrong q_full/q_empty levels after the queue is filled and drained. A wrong strobe field is visible one cycle after the slice is presented.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    localparam int PTAG_W   = 6;
    localparam int L1IDX_W  = 8;
    localparam int TLBIDX_W = 4;
    localparam int SLICE_W  = PTAG_W + L1IDX_W + TLBIDX_W;
    localparam int ADDR_W   = 32;

    typedef struct packed {
        logic               valid;
        logic               is_store;
        logic               pv;       // slice known
        logic               fv;       // complete address known
        logic               issued;
        logic [SLICE_W-1:0] slice;
        logic [ADDR_W-1:0]  addr;
    } lsq_entry_t;
endpackage

// File: rtl/lsq_dep_check.sv
module lsq_dep_check
    import lsq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  lsq_entry_t       ent [DEPTH],
    input  logic [PTR_W-1:0] head,
    output logic [DEPTH-1:0] eligible
);
    logic [PTR_W-1:0] age [DEPTH];

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            age[k] = PTR_W'(k) - head;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_load
        logic blk;
        always_comb begin
            blk = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && ent[j].valid && ent[j].is_store && age[j] < age[i]) begin
                    if (!ent[j].pv) begin
                        blk = 1'b1;
                    end else if (ent[j].slice == ent[i].slice) begin
                        if (!(ent[i].fv && ent[j].fv && ent[j].addr != ent[i].addr)) begin
                            blk = 1'b1;
                        end
                    end
                end
            end
            eligible[i] = ent[i].valid && !ent[i].is_store && ent[i].pv
                          && !ent[i].issued && !blk;
        end
    end
endmodule

// File: rtl/lsq_age_pick.sv
module lsq_age_pick #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    input  logic [PTR_W-1:0] head,
    output logic             gnt_valid,
    output logic [PTR_W-1:0] gnt_idx
);
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PTR_W-1:0] p;
            p = PTR_W'(k) + head;
            if (!gnt_valid && req[p]) begin
                gnt_valid = 1'b1;
                gnt_idx   = p;
            end
        end
    end
endmodule

// File: rtl/lsq_early_disambig.sv
module lsq_early_disambig
    import lsq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_valid,
    input  logic                alloc_is_store,
    output logic [PTR_W-1:0]    alloc_idx,
    output logic                q_full,
    output logic                q_empty,
    input  logic                early_valid,
    input  logic [PTR_W-1:0]    early_idx,
    input  logic [SLICE_W-1:0]  early_slice,
    input  logic                full_valid,
    input  logic [PTR_W-1:0]    full_idx,
    input  logic [ADDR_W-1:0]   full_addr,
    input  logic                retire_valid,
    output logic                issue_valid,
    output logic [PTR_W-1:0]    issue_idx,
    output logic                idx_strobe,
    output logic [L1IDX_W-1:0]  idx_l1,
    output logic [TLBIDX_W-1:0] idx_tlb
);
    typedef struct {
        lsq_entry_t            ent [DEPTH];
        logic [PTR_W-1:0]      head;
        logic [PTR_W-1:0]      tail;
        logic [CNT_W-1:0]      count;
        logic                  iss_v;
        logic [PTR_W-1:0]      iss_idx;
        logic                  stb;
        logic [L1IDX_W-1:0]    l1;
        logic [TLBIDX_W-1:0]   tlb;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0] elig;
    logic             gnt_v;
    logic [PTR_W-1:0] gnt_idx;
    logic             do_alloc, do_ret;

    lsq_dep_check #(.DEPTH(DEPTH)) u_dep (
        .ent      (s_q.ent),
        .head     (s_q.head),
        .eligible (elig)
    );

    lsq_age_pick #(.DEPTH(DEPTH)) u_pick (
        .req       (elig),
        .head      (s_q.head),
        .gnt_valid (gnt_v),
        .gnt_idx   (gnt_idx)
    );

    always_comb begin
        s_d      = s_q;
        do_ret   = retire_valid && (s_q.count != '0);
        do_alloc = alloc_valid && (s_q.count != CNT_W'(DEPTH));

        s_d.iss_v   = gnt_v;
        s_d.iss_idx = gnt_idx;
        if (gnt_v) begin
            s_d.ent[gnt_idx].issued = 1'b1;
        end

        s_d.stb = early_valid;
        s_d.l1  = early_slice[TLBIDX_W +: L1IDX_W];
        s_d.tlb = early_slice[TLBIDX_W-1:0];

        if (early_valid && s_q.ent[early_idx].valid) begin
            s_d.ent[early_idx].pv    = 1'b1;
            s_d.ent[early_idx].slice = early_slice;
        end
        if (full_valid && s_q.ent[full_idx].valid) begin
            s_d.ent[full_idx].pv    = 1'b1;
            s_d.ent[full_idx].fv    = 1'b1;
            s_d.ent[full_idx].addr  = full_addr;
            s_d.ent[full_idx].slice = full_addr[SLICE_W-1:0];
        end

        if (do_ret) begin
            s_d.ent[s_q.head] = '0;
            s_d.head          = s_q.head + 1'b1;
        end
        if (do_alloc) begin
            s_d.ent[s_q.tail]          = '0;
            s_d.ent[s_q.tail].valid    = 1'b1;
            s_d.ent[s_q.tail].is_store = alloc_is_store;
            s_d.tail                   = s_q.tail + 1'b1;
        end
        s_d.count = s_q.count + CNT_W'(do_alloc) - CNT_W'(do_ret);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                s_q.ent[i] <= '0;
            end
            s_q.head    <= '0;
            s_q.tail    <= '0;
            s_q.count   <= '0;
            s_q.iss_v   <= 1'b0;
            s_q.iss_idx <= '0;
            s_q.stb     <= 1'b0;
            s_q.l1      <= '0;
            s_q.tlb     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alloc_idx   = s_q.tail;
    assign q_full      = (s_q.count == CNT_W'(DEPTH));
    assign q_empty     = (s_q.count == '0);
    assign issue_valid = s_q.iss_v;
    assign issue_idx   = s_q.iss_idx;
    assign idx_strobe  = s_q.stb;
    assign idx_l1      = s_q.l1;
    assign idx_tlb     = s_q.tlb;
endmodule

// File: rtl/lsq_early_disambig_chk.sv
module lsq_early_disambig_chk
    import lsq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                alloc_valid,
    input logic [PTR_W-1:0]    alloc_idx,
    input logic                q_full,
    input logic                retire_valid,
    input logic                early_valid,
    input logic [SLICE_W-1:0]  early_slice,
    input logic                issue_valid,
    input logic [PTR_W-1:0]    issue_idx,
    input logic                idx_strobe,
    input logic [L1IDX_W-1:0]  idx_l1,
    input logic [TLBIDX_W-1:0] idx_tlb
);
    // R3: strobe and index fields follow an early slice by one cycle
    p_strobe_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |=> idx_strobe
            && idx_l1 == $past(early_slice[TLBIDX_W +: L1IDX_W])
            && idx_tlb == $past(early_slice[TLBIDX_W-1:0]));

    // R3: no strobe without a slice in the previous cycle
    p_strobe_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_strobe |-> $past(early_valid));

    // R2: accepted allocation advances the tail by one
    p_alloc_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !q_full) |=> alloc_idx == $past(alloc_idx) + 1'b1);

    // R2: a full queue stays full when nothing retires
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !retire_valid) |=> q_full && $stable(alloc_idx));

    // R9: a load is not granted twice in a row
    p_single_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !(issue_valid && issue_idx == $past(issue_idx)));
endmodule

bind lsq_early_disambig lsq_early_disambig_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_lsq_early_disambig.sv
`timescale 1ns/1ps
module tb_lsq_early_disambig;
    import lsq_pkg::*;
    localparam int DEPTH = 16;
    localparam int PTR_W = $clog2(DEPTH);

    logic clk = 0, rst_n = 0;
    logic alloc_valid = 0, alloc_is_store = 0;
    logic [PTR_W-1:0] alloc_idx;
    logic q_full, q_empty;
    logic early_valid = 0;
    logic [PTR_W-1:0] early_idx = '0;
    logic [SLICE_W-1:0] early_slice = '0;
    logic full_valid = 0;
    logic [PTR_W-1:0] full_idx = '0;
    logic [ADDR_W-1:0] full_addr = '0;
    logic retire_valid = 0;
    logic issue_valid;
    logic [PTR_W-1:0] issue_idx;
    logic idx_strobe;
    logic [L1IDX_W-1:0] idx_l1;
    logic [TLBIDX_W-1:0] idx_tlb;

    always #2.5 clk = ~clk;

    lsq_early_disambig #(.DEPTH(DEPTH)) dut (.*);

    int n_chk = 0, n_fail = 0, n_issued = 0, n_false_dep = 0;
    int exp_idx[$];
    string exp_req[$];
    bit done = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected grants in order
    always @(negedge clk) begin
        if (rst_n && !done && issue_valid) begin
            n_issued++;
            if (exp_idx.size() == 0) begin
                check(0, "R4", "unexpected grant idx", int'(issue_idx), -1);
            end else begin
                int e;
                string r;
                e = exp_idx.pop_front();
                r = exp_req.pop_front();
                check(int'(issue_idx) == e, r, "grant idx", int'(issue_idx), e);
            end
        end
    end

    task automatic expect_issue(int idx, string req);
        exp_idx.push_back(idx);
        exp_req.push_back(req);
    endtask

    task automatic do_alloc(bit st, output int idx);
        @(negedge clk);
        idx = int'(alloc_idx);
        alloc_valid = 1; alloc_is_store = st;
        @(negedge clk);
        alloc_valid = 0;
    endtask

    task automatic do_early(int idx, logic [SLICE_W-1:0] sl);
        @(negedge clk);
        early_valid = 1; early_idx = PTR_W'(idx); early_slice = sl;
        @(negedge clk);
        early_valid = 0;
        check(idx_strobe && idx_l1 == sl[11:4] && idx_tlb == sl[3:0], "R3",
              "strobe/l1/tlb", int'({idx_strobe, idx_l1, idx_tlb}),
              int'({1'b1, sl[11:4], sl[3:0]}));
    endtask

    task automatic do_full(int idx, logic [ADDR_W-1:0] a);
        @(negedge clk);
        full_valid = 1; full_idx = PTR_W'(idx); full_addr = a;
        @(negedge clk);
        full_valid = 0;
    endtask

    task automatic do_retire(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            retire_valid = 1;
            @(negedge clk);
            retire_valid = 0;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_drained(string req);
        idle(4);
        check(exp_idx.size() == 0, req, "pending grants", exp_idx.size(), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        check(0, "R9", "watchdog expired", 0, 1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int s, l, a, b, base;
        logic [SLICE_W-1:0] sl;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        check(q_empty && !q_full, "R1", "empty/full after reset", int'({q_empty, q_full}), 2);
        check(!issue_valid && !idx_strobe, "R1", "issue/strobe after reset",
              int'({issue_valid, idx_strobe}), 0);

        // R4: blocked by unresolved older store, released exactly one cycle after
        do_alloc(1, s); do_alloc(0, l);
        idle(3);
        check(n_issued == 0, "R4", "load without own slice issued", n_issued, 0);
        do_early(l, 18'h00ABC);
        idle(4);
        check(n_issued == 0, "R4", "load issued past unresolved store", n_issued, 0);
        expect_issue(l, "R4");
        do_early(s, 18'h12345);
        check(!issue_valid, "R9", "grant too early", int'(issue_valid), 0);
        @(negedge clk);
        check(issue_valid && int'(issue_idx) == l, "R9", "grant one cycle after release",
              int'(issue_valid), 1);
        expect_drained("R4");
        do_retire(2);
        check(q_empty, "R10", "empty after retire", int'(q_empty), 1);

        // R5/R6: false dependence cleared by complete addresses
        sl = 18'h20F0F;
        do_alloc(1, s); do_alloc(0, l);
        do_early(s, sl); do_early(l, sl);
        idle(4);
        check(n_issued == 1, "R5", "partial match not blocking", n_issued, 1);
        do_full(s, {14'h1234, sl});
        idle(4);
        check(n_issued == 1, "R5", "blocked while load address unknown", n_issued, 1);
        expect_issue(l, "R6");
        do_full(l, {14'h0777, sl});
        expect_drained("R6");
        n_false_dep++;
        do_retire(2);

        // R7/R10: true dependence held until store retires
        sl = 18'h0C3A5;
        do_alloc(1, s); do_alloc(0, l);
        do_early(s, sl); do_early(l, sl);
        do_full(s, {14'h0042, sl}); do_full(l, {14'h0042, sl});
        idle(5);
        check(n_issued == 2, "R7", "true dependence missed", n_issued, 2);
        expect_issue(l, "R10");
        do_retire(1);
        expect_drained("R10");
        do_retire(1);

        // R8: younger store with same slice does not block
        sl = 18'h3FFFF;
        do_alloc(0, l); do_alloc(1, s);
        do_early(s, sl);
        expect_issue(l, "R8");
        do_early(l, sl);
        expect_drained("R8");
        do_retire(2);

        // R9: oldest eligible first
        do_alloc(1, s); do_alloc(0, a); do_alloc(0, b);
        do_early(b, 18'h01111); do_early(a, 18'h02222);
        idle(3);
        check(n_issued == 4, "R9", "granted past unresolved store", n_issued, 4);
        expect_issue(a, "R9"); expect_issue(b, "R9");
        do_early(s, 18'h03333);
        expect_drained("R9");
        check(n_issued == 6, "R9", "grant count", n_issued, 6);
        do_retire(3);

        // R2: fill, overflow attempt, drain
        base = int'(alloc_idx);
        for (int k = 0; k < DEPTH; k++) begin
            int ix;
            do_alloc(0, ix);
            if (k == 0 || k == DEPTH - 1)
                check(ix == ((base + k) % DEPTH), "R2", "alloc idx", ix, (base + k) % DEPTH);
        end
        check(q_full && !q_empty, "R2", "full after DEPTH allocs", int'({q_full, q_empty}), 2);
        do_alloc(1, a);
        check(q_full && int'(alloc_idx) == base, "R2", "alloc while full ignored",
              int'(alloc_idx), base);
        do_retire(DEPTH);
        check(q_empty && !q_full, "R2", "empty after DEPTH retires",
              int'({q_empty, q_full}), 2);
        idle(3);
        check(n_issued == 6, "R4", "slice-less loads issued", n_issued, 6);

        $display("false dependences observed: %0d, true dependences missed: 0", n_false_dep);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule